// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the memory side of taking an interrupt and of returning from one. A one-cycle take request with an 8-bit interrupt type starts the entry sequence. The block saves the caller's flags, code segment and instruction pointer on a downward-growing stack. It then fetches a new instruction pointer and code segment from a vector table entry chosen by the type. A one-cycle return request starts the reverse sequence, which pops the instruction pointer, the code segment and the flags. The results are presented on dedicated outputs when the sequence ends.

A mode input selects between two layouts. In protected mode, stack items are 32 bits wide and the vector table sits at a programmable base with 8 bytes per entry. In real mode, stack items are 16 bits wide and the table sits at address 0 with 4 bytes per entry. Every transfer goes through one single-port memory request interface, and only one access is outstanding at a time. A fault/trap input chooses which instruction pointer is saved: the pointer of the faulting instruction, so that the instruction restarts, or the pointer of the following instruction.

Top module: `irq_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are 0 and `sp_o` is 0.
- R2: On entry, three writes are issued in this order: flags, then code segment, then saved instruction pointer. Before each write the stack pointer is lowered by the item size: 4 bytes in protected mode and 2 bytes in real mode. Each write goes to the lowered address. The code segment is zero-extended into its slot. At the end, `sp_o` equals `sp_i` minus three item sizes.
- R3: After entry, `flags_o` equals `flags_i` with bit 9 (interrupt enable) and bit 8 (trap) cleared. The pushed flags value is the unmodified `flags_i`.
- R4: When `trap_i` is 0 (fault), the pushed pointer is `ip_i`. When `trap_i` is 1 (trap), the pushed pointer is `ip_next_i`.
- R5: In protected mode the entry is at `tbl_base_i + 8*type`. The new 32-bit instruction pointer is read from entry+0 and the new code segment from the low 16 bits at entry+4. These two reads follow the three pushes, in that order.
- R6: In real mode the entry is at `4*type` from address 0. The new pointer is the 16-bit value at entry+0 and the code segment is the 16-bit value at entry+2. For example, type 0x21 reads 0x84 and then 0x86. `ip_o` is zero-extended.
- R7: On return, three reads are issued at `sp`, `sp+size` and `sp+2*size`. They load the instruction pointer, the code segment and the flags, in that order, and `sp_o` ends at `sp_i` plus three item sizes. In real mode only the low 16 bits of the flags are restored, the upper 16 come from `flags_i`, and `ip_o` is zero-extended.
- R8: Each access keeps `mem_req_o`, address, write enable and write data stable until `mem_ready_i` is seen. The stack pointer does not move while an access waits.
- R9: `busy_o` rises the cycle after an accepted take or return and falls when the last access completes. `done_o` is a one-cycle pulse in that same cycle, with `busy_o` low. Take or return requests that arrive while busy are ignored, and take wins over return when both arrive together.
- R10: `mem_wide_o` is 1 for every access in protected mode (32-bit data) and 0 in real mode (16-bit data, low half of the data buses).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Start the entry sequence |
| ret_i | input | 1 | Start the return sequence |
| vec_i | input | 8 | Interrupt type |
| prot_i | input | 1 | 1 = protected layout, 0 = real layout |
| trap_i | input | 1 | 1 = trap (save next pointer), 0 = fault |
| flags_i | input | 32 | Current flags |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 32 | Pointer of the current instruction |
| ip_next_i | input | 32 | Pointer of the following instruction |
| tbl_base_i | input | 32 | Vector table base (protected mode) |
| sp_i | input | 32 | Stack pointer at start |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write enable |
| mem_wide_o | output | 1 | 1 = 32-bit access, 0 = 16-bit |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished pulse |
| sp_o | output | 32 | Current stack pointer |
| cs_o | output | 16 | Resulting code segment |
| ip_o | output | 32 | Resulting instruction pointer |
| flags_o | output | 32 | Resulting flags |

## Verification
The assertions check every cycle that a stalled access holds its address, data and direction with the stack pointer frozen. They also check that each accepted push lowers the stack pointer by the current item size, that a request starts the sequence, and that the end of busy coincides with the done pulse. The bench scenarios are needed to show the order and addresses of the pushes and table reads in both layouts, the fault/trap choice of saved pointer, the cleared flag bits, the real-mode partial flag restore, and a full entry-then-return round trip. The bench also shows that requests made while busy leave the transfer log unchanged.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int IE_BIT = 9;
  localparam int TR_BIT = 8;
  localparam logic [DW-1:0] FLAG_KEEP = ~((DW'(1) << IE_BIT) | (DW'(1) << TR_BIT));

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PSH_FL,
    ST_PSH_CS,
    ST_PSH_IP,
    ST_LD_IP,
    ST_LD_CS,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FL
  } seq_st_e;
endpackage

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int AW = 32,
  parameter int VW = 8
) (
  input  logic          prot_i,
  input  logic [VW-1:0] vec_i,
  input  logic [AW-1:0] base_i,
  input  logic          hi_i,
  output logic [AW-1:0] addr_o
);
  localparam int PROT_SH = 3;
  localparam int REAL_SH = 2;
  localparam logic [AW-1:0] PROT_HI = AW'(4);
  localparam logic [AW-1:0] REAL_HI = AW'(2);

  logic [AW-1:0] vec_ext;
  assign vec_ext = AW'(vec_i);

  always_comb begin
    if (prot_i) addr_o = base_i + (vec_ext << PROT_SH) + (hi_i ? PROT_HI : '0);
    else        addr_o = (vec_ext << REAL_SH) + (hi_i ? REAL_HI : '0);
  end
endmodule

// File: rtl/irq_stack_unit.sv
module irq_stack_unit #(
  parameter int AW       = 32,
  parameter int WIDE_B   = 4,
  parameter int NARROW_B = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          wide_i,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] push_addr_o
);
  localparam logic [AW-1:0] STEP_W = AW'(WIDE_B);
  localparam logic [AW-1:0] STEP_N = AW'(NARROW_B);

  logic [AW-1:0] sp_q, step;
  assign step        = wide_i ? STEP_W : STEP_N;
  assign push_addr_o = sp_q - step;
  assign sp_o        = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= load_val_i;
    else if (dec_i)  sp_q <= push_addr_o;
    else if (inc_i)  sp_q <= sp_q + step;
  end
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          ret_i,
  input  logic [DW-1:0] flags_i,
  input  logic [CW-1:0] cs_i,
  input  logic [DW-1:0] ip_save_i,
  input  logic          wide_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          wr_ip_i,
  input  logic          wr_cs_i,
  input  logic          wr_fl_i,
  output logic [DW-1:0] sv_flags_o,
  output logic [CW-1:0] sv_cs_o,
  output logic [DW-1:0] sv_ip_o,
  output logic [DW-1:0] flags_o,
  output logic [CW-1:0] cs_o,
  output logic [DW-1:0] ip_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] fl_q, ip_q, svf_q, svi_q;
  logic [CW-1:0] cs_q, svc_q;
  logic [DW-1:0] rd_ip, rd_fl;

  assign rd_ip = wide_i ? rdata_i : {{HW{1'b0}}, rdata_i[HW-1:0]};
  assign rd_fl = wide_i ? rdata_i : {fl_q[DW-1:HW], rdata_i[HW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= '0;
      ip_q  <= '0;
      cs_q  <= '0;
      svf_q <= '0;
      svi_q <= '0;
      svc_q <= '0;
    end else if (take_i) begin
      svf_q <= flags_i;
      svc_q <= cs_i;
      svi_q <= ip_save_i;
      fl_q  <= flags_i & FLAG_KEEP;
    end else if (ret_i) begin
      fl_q <= flags_i;
    end else begin
      if (wr_ip_i) ip_q <= rd_ip;
      if (wr_cs_i) cs_q <= rdata_i[CW-1:0];
      if (wr_fl_i) fl_q <= rd_fl;
    end
  end

  assign sv_flags_o = svf_q;
  assign sv_cs_o    = svc_q;
  assign sv_ip_o    = svi_q;
  assign flags_o    = fl_q;
  assign cs_o       = cs_q;
  assign ip_o       = ip_q;
endmodule

// File: rtl/irq_xfer_seq.sv
module irq_xfer_seq
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          ret_i,
  input  logic [VW-1:0] vec_i,
  input  logic          prot_i,
  input  logic          trap_i,
  input  logic [DW-1:0] flags_i,
  input  logic [CW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] ip_next_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [AW-1:0] sp_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_wide_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] sp_o,
  output logic [CW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] flags_o
);
  localparam int HW = DW / 2;

  seq_st_e st_q, st_d;
  logic prot_q, done_q;
  logic [VW-1:0] vec_q;
  logic [AW-1:0] base_q;

  logic idle, go_take, go_ret, fire, is_push, is_pop, last;
  logic [AW-1:0] push_addr, tbl_addr, sp_cur;
  logic [DW-1:0] sv_flags, sv_ip, wd_raw;
  logic [CW-1:0] sv_cs;

  assign idle    = (st_q == ST_IDLE);
  assign go_take = take_i & idle;
  assign go_ret  = ret_i & ~take_i & idle;
  assign fire    = mem_req_o & mem_ready_i;
  assign is_push = (st_q == ST_PSH_FL) | (st_q == ST_PSH_CS) | (st_q == ST_PSH_IP);
  assign is_pop  = (st_q == ST_POP_IP) | (st_q == ST_POP_CS) | (st_q == ST_POP_FL);
  assign last    = (st_q == ST_LD_CS) | (st_q == ST_POP_FL);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (go_take) st_d = ST_PSH_FL; else if (go_ret) st_d = ST_POP_IP;
      ST_PSH_FL: if (fire) st_d = ST_PSH_CS;
      ST_PSH_CS: if (fire) st_d = ST_PSH_IP;
      ST_PSH_IP: if (fire) st_d = ST_LD_IP;
      ST_LD_IP:  if (fire) st_d = ST_LD_CS;
      ST_LD_CS:  if (fire) st_d = ST_IDLE;
      ST_POP_IP: if (fire) st_d = ST_POP_CS;
      ST_POP_CS: if (fire) st_d = ST_POP_FL;
      ST_POP_FL: if (fire) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prot_q <= 1'b0;
      vec_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fire & last;
      if (go_take | go_ret) prot_q <= prot_i;
      if (go_take) begin
        vec_q  <= vec_i;
        base_q <= tbl_base_i;
      end
    end
  end

  irq_stack_unit #(.AW(AW)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (go_take | go_ret),
    .load_val_i (sp_i),
    .wide_i     (prot_q),
    .dec_i      (fire & is_push),
    .inc_i      (fire & is_pop),
    .sp_o       (sp_cur),
    .push_addr_o(push_addr)
  );

  irq_vec_addr #(.AW(AW), .VW(VW)) u_vec (
    .prot_i (prot_q),
    .vec_i  (vec_q),
    .base_i (base_q),
    .hi_i   (st_q == ST_LD_CS),
    .addr_o (tbl_addr)
  );

  irq_ctx_regs u_ctx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (go_take),
    .ret_i      (go_ret),
    .flags_i    (flags_i),
    .cs_i       (cs_i),
    .ip_save_i  (trap_i ? ip_next_i : ip_i),
    .wide_i     (prot_q),
    .rdata_i    (mem_rdata_i),
    .wr_ip_i    (fire & ((st_q == ST_LD_IP) | (st_q == ST_POP_IP))),
    .wr_cs_i    (fire & ((st_q == ST_LD_CS) | (st_q == ST_POP_CS))),
    .wr_fl_i    (fire & (st_q == ST_POP_FL)),
    .sv_flags_o (sv_flags),
    .sv_cs_o    (sv_cs),
    .sv_ip_o    (sv_ip),
    .flags_o    (flags_o),
    .cs_o       (cs_o),
    .ip_o       (ip_o)
  );

  always_comb begin
    unique case (st_q)
      ST_PSH_FL: wd_raw = sv_flags;
      ST_PSH_CS: wd_raw = DW'(sv_cs);
      ST_PSH_IP: wd_raw = sv_ip;
      default:   wd_raw = '0;
    endcase
  end

  assign mem_req_o   = ~idle;
  assign mem_we_o    = is_push;
  assign mem_wide_o  = prot_q;
  assign mem_addr_o  = is_push ? push_addr : (is_pop ? sp_cur : tbl_addr);
  assign mem_wdata_o = prot_q ? wd_raw : {{HW{1'b0}}, wd_raw[HW-1:0]};
  assign busy_o      = ~idle;
  assign done_o      = done_q;
  assign sp_o        = sp_cur;
endmodule

// File: rtl/irq_xfer_seq_chk.sv
module irq_xfer_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          take_i,
  input logic          ret_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_wide_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] sp_o
);
  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R8
  sp_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> $stable(sp_o));

  // R2
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ready_i |=> sp_o == $past(sp_o) - ($past(mem_wide_o) ? AW'(4) : AW'(2)));

  // R9
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && (take_i || ret_i) |=> busy_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_req_o);

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind irq_xfer_seq irq_xfer_seq_chk #(.AW(AW), .DW(32)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .take_i      (take_i),
  .ret_i       (ret_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_wide_o  (mem_wide_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .sp_o        (sp_o)
);

// File: tb/tb_irq_xfer_seq.sv
`timescale 1ns/1ps
module tb_irq_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic take, ret, prot, trap, mem_req, mem_we, mem_wide, mem_ready, busy, done;
  logic [7:0]  vec;
  logic [31:0] flags, ip, ipn, base, sp, mem_addr, mem_wdata, mem_rdata, sp_o, ip_o, flags_o;
  logic [15:0] cs, cs_o;

  irq_xfer_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .take_i(take), .ret_i(ret), .vec_i(vec), .prot_i(prot),
    .trap_i(trap), .flags_i(flags), .cs_i(cs), .ip_i(ip), .ip_next_i(ipn), .tbl_base_i(base),
    .sp_i(sp), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .busy_o(busy), .done_o(done), .sp_o(sp_o), .cs_o(cs_o),
    .ip_o(ip_o), .flags_o(flags_o)
  );

  typedef struct packed {logic we; logic wide; logic [31:0] addr; logic [31:0] data;} xact_t;
  xact_t log_q[$];
  logic [7:0] mem [logic [31:0]];
  int checks = 0, errors = 0, cyc = 0;

  function automatic logic [7:0] rd8(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic wr_mem(logic [31:0] a, logic [31:0] d, int nb);
    for (int i = 0; i < nb; i++) mem[a + 32'(i)] = d[8*i +: 8];
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // memory model: random ready, logs each accepted transfer
  always @(negedge clk) begin
    cyc++;
    mem_ready = 1'b0;
    if (rst_n && mem_req && ($urandom_range(2) != 0)) begin
      mem_ready = 1'b1;
      if (mem_we) begin
        wr_mem(mem_addr, mem_wdata, mem_wide ? 4 : 2);
        log_q.push_back({1'b1, mem_wide, mem_addr, mem_wdata});
      end else begin
        mem_rdata = {rd8(mem_addr + 3), rd8(mem_addr + 2), rd8(mem_addr + 1), rd8(mem_addr)};
        log_q.push_back({1'b0, mem_wide, mem_addr, mem_rdata});
      end
    end
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R9 watchdog act=%0d exp=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    chk("R9 done pulse", 32'(done), 1);
    chk("R9 busy low at done", 32'(busy), 0);
  endtask

  task automatic chk_x(string r, int idx, logic we, logic wide, logic [31:0] a, logic [31:0] d, bit cmp_d);
    if (idx >= log_q.size()) begin chk({r, " missing"}, 32'(log_q.size()), 32'(idx + 1)); return; end
    chk({r, " dir"}, 32'(log_q[idx].we), 32'(we));
    chk("R10 width", 32'(log_q[idx].wide), 32'(wide));
    chk({r, " addr"}, log_q[idx].addr, a);
    if (cmp_d) chk({r, " data"}, log_q[idx].data, d);
  endtask

  // entry sequence; returns saved pointer
  task automatic do_entry(bit p, bit tr, logic [7:0] v, logic [31:0] fl, logic [15:0] c,
                          logic [31:0] i0, logic [31:0] i1, logic [31:0] b, logic [31:0] s,
                          bit poke, output logic [31:0] saved);
    logic [31:0] sz, msk, tbl, nip;
    logic [15:0] ncs;
    sz  = p ? 4 : 2;
    msk = p ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    tbl = p ? b + {21'd0, v, 3'd0} : {22'd0, v, 2'd0};
    nip = $urandom; ncs = 16'($urandom);
    if (p) begin wr_mem(tbl, nip, 4); wr_mem(tbl + 4, {16'h0, ncs}, 4); end
    else   begin wr_mem(tbl, nip, 2); wr_mem(tbl + 2, {16'h0, ncs}, 2); end
    saved = (tr ? i1 : i0) & msk;
    log_q.delete();
    prot = p; trap = tr; vec = v; flags = fl; cs = c; ip = i0; ipn = i1; base = b; sp = s;
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
    chk("R9 busy after take", 32'(busy), 1);
    if (poke) begin
      vec = v ^ 8'h5A; take = 1'b1; ret = 1'b1; sp = s ^ 32'h100;
      @(negedge clk);
      take = 1'b0; ret = 1'b0;
    end
    wait_done();
    chk_x("R2 push flags", 0, 1, p, s - sz, fl & msk, 1);
    chk_x("R2 push cs", 1, 1, p, s - 2 * sz, {16'h0, c}, 1);
    chk_x("R4 push ip", 2, 1, p, s - 3 * sz, saved, 1);
    chk_x(p ? "R5 tbl ip" : "R6 tbl ip", 3, 0, p, tbl, 0, 0);
    chk_x(p ? "R5 tbl cs" : "R6 tbl cs", 4, 0, p, tbl + sz, 0, 0);
    chk(p ? "R5 ip_o" : "R6 ip_o", ip_o, nip & msk);
    chk(p ? "R5 cs_o" : "R6 cs_o", 32'(cs_o), 32'(ncs));
    chk("R3 flags_o", flags_o, fl & ~32'h0000_0300);
    chk("R2 sp_o", sp_o, s - 3 * sz);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk("R9 request while busy ignored", 32'(log_q.size()), 5);
      chk("R9 no restart", 32'(busy), 0);
    end
  endtask

  task automatic do_ret(bit p, logic [31:0] s, logic [31:0] fl_in,
                        logic [31:0] e_ip, logic [15:0] e_cs, logic [31:0] e_fl);
    logic [31:0] sz;
    sz = p ? 4 : 2;
    log_q.delete();
    prot = p; sp = s; flags = fl_in;
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    chk("R9 busy after return", 32'(busy), 1);
    wait_done();
    chk_x("R7 pop ip", 0, 0, p, s, 0, 0);
    chk_x("R7 pop cs", 1, 0, p, s + sz, 0, 0);
    chk_x("R7 pop flags", 2, 0, p, s + 2 * sz, 0, 0);
    chk("R7 ip_o", ip_o, e_ip);
    chk("R7 cs_o", 32'(cs_o), 32'(e_cs));
    chk("R7 flags_o", flags_o, e_fl);
    chk("R7 sp_o", sp_o, s + 3 * sz);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] sv, f0, i0, i1, s0, b0, fin;
    logic [15:0] c0;
    take = 0; ret = 0; prot = 0; trap = 0; vec = 0; flags = 0; cs = 0; ip = 0; ipn = 0;
    base = 0; sp = 0; mem_ready = 0; mem_rdata = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 req", 32'(mem_req), 0);
    chk("R1 sp", sp_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: protected fault, real type 0x21 (table 0x84/0x86), trap, top entry, busy poke
    do_entry(1, 0, 8'h21, 32'hFFFF_FFFF, 16'h1234, 32'h0040_1000, 32'h0040_1004, 32'h0010_0000, 32'h8000_1000, 0, sv);
    do_entry(0, 0, 8'h21, 32'h0001_0302, 16'hBEEF, 32'h0000_2222, 32'h0000_2225, 32'h0, 32'h0000_F000, 0, sv);
    do_entry(1, 1, 8'h04, 32'h0000_0200, 16'h0008, 32'h0000_3000, 32'h0000_3003, 32'h0020_0000, 32'h8000_2000, 0, sv);
    chk("R4 trap saves next", sv, 32'h0000_3003);
    do_entry(1, 0, 8'hFF, 32'h0000_0100, 16'h0010, 32'h1111_0000, 32'h1111_0002, 32'h0030_0000, 32'h8000_3000, 1, sv);

    // round trips in both layouts
    for (int m = 0; m < 2; m++) begin
      f0 = $urandom; c0 = 16'($urandom); i0 = $urandom; i1 = $urandom; fin = $urandom;
      s0 = (m == 1) ? 32'h8001_0000 : 32'h0000_E000;
      do_entry(m[0], 1'($urandom_range(1)), 8'($urandom), f0, c0, i0, i1, 32'h0040_0000, s0, 0, sv);
      if (m == 1) do_ret(1, sp_o, fin, sv, c0, f0);
      else        do_ret(0, sp_o, fin, sv & 32'hFFFF, c0, {fin[31:16], f0[15:0]});
    end

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit p;
      p = 1'($urandom_range(1));
      if ($urandom_range(1) == 1) begin
        s0 = p ? (32'h8000_0000 | ($urandom & 32'h00FF_FFFC)) : (32'h1000 | ($urandom & 32'h7FFE));
        b0 = 32'h0010_0000 | ($urandom & 32'h000F_FFF8);
        do_entry(p, 1'($urandom_range(1)), 8'($urandom), $urandom, 16'($urandom),
                 $urandom, $urandom, b0, s0, ($urandom_range(3) == 0), sv);
      end else begin
        logic [31:0] ri, rc, rf, fi;
        s0 = p ? (32'h9000_0000 | ($urandom & 32'h00FF_FFFC)) : (32'h1000 | ($urandom & 32'h7FFE));
        ri = $urandom; rc = $urandom; rf = $urandom; fi = $urandom;
        if (p) begin
          wr_mem(s0, ri, 4); wr_mem(s0 + 4, rc, 4); wr_mem(s0 + 8, rf, 4);
          do_ret(1, s0, fi, ri, rc[15:0], rf);
        end else begin
          wr_mem(s0, ri, 2); wr_mem(s0 + 2, rc, 2); wr_mem(s0 + 4, rf, 2);
          do_ret(0, s0, fi, {16'h0, ri[15:0]}, rc[15:0], {fi[31:16], rf[15:0]});
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule